// File: doc/BRIEF.md
# Port Change Key-Wakeup Detector

This block watches an 8-bit key port and raises a wakeup flag as soon as any pin differs from a snapshot that software captured earlier. A capture strobe copies the current synchronized pin state into the snapshot register. A separate enable register arms the comparison. While the block is armed, any difference between the live pins and the snapshot sets a sticky wakeup flag. The flag stays set until the clear input drops it.

The usual flow has five steps. Software captures the idle state of the keys, sets the enable and puts the system to sleep. A key press or release then sets the flag, and the flag is used as the wakeup or interrupt request. The handler recaptures the snapshot and clears the flag. Because the comparison runs against a chosen snapshot, the block responds to a change in either direction on any pin, not to a fixed level or to one edge.

Top module: `key_wake_det`

## Requirements
- R1: After reset `wake_o` is 0, the detector is disabled and the snapshot holds all zeros. Enabling it with all pins at 0 therefore raises no wakeup.
- R2: Each pin passes through a two-flop synchronizer. A pin change that is driven before clock edge 1 reaches the comparison after edge 2. While the block is enabled, `wake_o` rises after edge 3 and not earlier.
- R3: A cycle with `snap_we_i` high loads the snapshot with the synchronized pin state of that cycle. Pins that stay at that value raise no wakeup afterwards.
- R4: While the enable register is 0, no pin state sets `wake_o`.
- R5: While the block is enabled, a difference in any pin between the synchronized state and the snapshot sets `wake_o` one cycle later.
- R6: `wake_o` stays at 1 after the pins return to the snapshot value, until `clr_i` is asserted.
- R7: When `clr_i` is high and no mismatch is detected, `wake_o` is 0 in the next cycle.
- R8: When `clr_i` is high while an enabled mismatch persists, `wake_o` stays 1.
- R9: A cycle with `snap_we_i` high never sets `wake_o`, even if the old snapshot differs from the pins.
- R10: A cycle with `en_we_i` high loads `en_wdata_i` into the enable register. A mismatch that is already present sets `wake_o` one cycle after the enable takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Asynchronous key port pins |
| snap_we_i | input | 1 | Strobe that captures the pin state into the snapshot |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 1 | Value written to the enable register |
| clr_i | input | 1 | Clears the wakeup flag |
| wake_o | output | 1 | Sticky wakeup flag |

## Verification
The hardest cases to reach are the ones where a strobe collides with an active mismatch. Examples are a recapture in the same cycle as a pending difference, a clear while the difference persists, and an enable write while the pins already differ from the snapshot. The stimulus first holds a pin pattern long enough to pass the synchronizer, then pulses the strobe on a chosen cycle, sometimes together with the clear. A behavioural reference model that delays the pins through a queue predicts `wake_o` on every cycle, so the sampling edge of each check is known.

// File: rtl/kw_pkg.sv
package kw_pkg;
  parameter int unsigned KW_PORT_W   = 8;
  parameter int unsigned KW_SYNC_LEN = 2;
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
  parameter int unsigned W   = kw_pkg::KW_PORT_W,
  parameter int unsigned LEN = kw_pkg::KW_SYNC_LEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [LEN];

  for (genvar s = 0; s < LEN; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[LEN-1];
endmodule

// File: rtl/kw_arm.sv
module kw_arm #(
  parameter int unsigned W = kw_pkg::KW_PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_s_i,
  input  logic         snap_we_i,
  input  logic         en_we_i,
  input  logic         en_wdata_i,
  output logic [W-1:0] snap_o,
  output logic         en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o <= '0;
      en_o   <= 1'b0;
    end else begin
      if (snap_we_i) snap_o <= pin_s_i;
      if (en_we_i)   en_o   <= en_wdata_i;
    end
  end

  assert_snap_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_we_i |=> snap_o == $past(pin_s_i));
  assert_en_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> en_o == $past(en_wdata_i));
endmodule

// File: rtl/kw_flag.sv
module kw_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= 1'b0;
    else         wake_o <= (wake_o & ~clr_i) | hit_i;
  end

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o && !clr_i |=> wake_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit_i |=> !wake_o);
  assert_reassert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && hit_i |=> wake_o);
endmodule

// File: rtl/key_wake_det.sv
module key_wake_det #(
  parameter int unsigned PORT_W   = kw_pkg::KW_PORT_W,
  parameter int unsigned SYNC_LEN = kw_pkg::KW_SYNC_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pins_i,
  input  logic              snap_we_i,
  input  logic              en_we_i,
  input  logic              en_wdata_i,
  input  logic              clr_i,
  output logic              wake_o
);
  logic [PORT_W-1:0] pin_s, snap_q;
  logic              en_q, hit;

  kw_sync #(.W(PORT_W), .LEN(SYNC_LEN)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pin_s)
  );

  kw_arm #(.W(PORT_W)) u_arm (
    .clk_i, .rst_ni, .pin_s_i(pin_s), .snap_we_i, .en_we_i, .en_wdata_i,
    .snap_o(snap_q), .en_o(en_q)
  );

  // recapture cycle is masked so a stale snapshot cannot fire
  assign hit = en_q & ~snap_we_i & (|(pin_s ^ snap_q));

  kw_flag u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i, .wake_o
  );

  assert_disabled_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !wake_o |=> !wake_o);
  assert_recapture_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_we_i && !wake_o |=> !wake_o);
  assert_mismatch_wakes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !snap_we_i && (pin_s != snap_q) |=> wake_o);
endmodule

// File: tb/key_wake_det_tb.sv
module key_wake_det_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       snap_we = 1'b0, en_we = 1'b0, en_wd = 1'b0, clr = 1'b0;
  logic       wake;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  key_wake_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .snap_we_i(snap_we),
    .en_we_i(en_we), .en_wdata_i(en_wd), .clr_i(clr), .wake_o(wake)
  );

  // reference model
  logic [7:0] pq[$];
  logic [7:0] m_snap;
  bit m_en, m_wake;
  initial begin pq = '{8'h00, 8'h00}; m_snap = '0; m_en = 0; m_wake = 0; end

  always @(posedge clk) if (rst_n) begin
    logic [7:0] seen;
    bit hit;
    seen = pq[0];
    hit = m_en && !snap_we && (seen != m_snap);
    m_wake = (m_wake && !clr) || hit;
    if (snap_we) m_snap = seen;
    if (en_we) m_en = en_wd;
    void'(pq.pop_front());
    pq.push_back(pins);
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (wake !== m_wake) begin
      errors++;
      $display("FAIL R5 model compare t=%0t: wake=%b expected=%b", $time, wake, m_wake);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, bit exp);
    checks++;
    if (wake !== exp) begin
      errors++;
      $display("FAIL %s: wake=%b expected=%b", req, wake, exp);
    end
  endtask

  task automatic pulse_en(bit v);
    en_we = 1; en_wd = v; step(1); en_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: run hung, wake=%b expected=done", wake);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 0);
    rst_n = 1;
    step(1);
    pulse_en(1);                     // R10 enable write
    step(3);
    chk("R1 zero snapshot", 0);
    pins = 8'h01;
    step(2);
    chk("R2 sync delay", 0);
    step(1);
    chk("R5 bit0 mismatch", 1);
    pins = 8'h00;
    step(4);
    chk("R6 sticky", 1);
    clr = 1; step(1); clr = 0;
    chk("R7 clear", 0);
    pins = 8'h80;
    step(4);
    chk("R5 bit7 mismatch", 1);
    clr = 1; step(1); clr = 0;
    chk("R8 clear while mismatch", 1);
    snap_we = 1; clr = 1; step(1); snap_we = 0; clr = 0;
    chk("R9 recapture cycle", 0);
    step(4);
    chk("R3 snapshot holds 0x80", 0);
    pins = 8'h55;
    step(3);
    chk("R5 multi-bit mismatch", 1);
    snap_we = 1; clr = 1; step(1); snap_we = 0; clr = 0;
    chk("R9 recapture over mismatch", 0);
    step(3);
    chk("R3 snapshot holds 0x55", 0);
    pulse_en(0);
    pins = 8'hAA;
    step(5);
    chk("R4 disabled", 0);
    pulse_en(1);
    chk("R10 enable edge", 0);
    step(1);
    chk("R10 pending mismatch fires", 1);
    pins = 8'h55;
    step(3);
    clr = 1; step(1); clr = 0;
    chk("R7 clear after match", 0);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule